// File: doc/BRIEF.md
# Three-Level Auxiliary Table Walker

The walker turns a 48-bit main-surface virtual address into the address of its auxiliary (compression metadata) data and a small format descriptor. The translation tables sit in memory as arrays of 64-bit entries. The walker reads them one entry at a time: first from a root table whose base comes from a configuration input, then through an intermediate table, and finally from a leaf table. Each entry carries a valid flag in bit 0. A clear flag ends the walk with a miss that names the level where the walk stopped.

A client offers a lookup with a valid/ready handshake. The walker then issues at most three reads on a single-outstanding memory read port, in level order. It returns one response, held until the client accepts it. A response is a hit with the decoded leaf fields, a miss with a level code, or an error when the memory flags a read as failed. Pointer fields taken from entries are made canonical by copying address bit 47 into bits 63:48 before they are used as table addresses.

Top module: `aux_walk_top`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0.
- R2: The first read of a walk goes to `base_addr + 8 * vaddr[47:36]`.
- R3: When the root entry is valid, the second read goes to canonical(entry[47:15] with bits 14:0 zero) + 8 * vaddr[35:24]. Canonical means bit 47 is copied into bits 63:48.
- R4: When the intermediate entry is valid, the third read goes to canonical(entry[47:13] with bits 12:0 zero) + 8 * vaddr[23:16].
- R5: A valid leaf gives status 0 (hit) with `rsp_aux_addr` = {leaf[47:8], 8'h00}, `rsp_tile` = leaf[53:52], `rsp_depth` = leaf[56:54], `rsp_chroma` = leaf[57] and `rsp_format` = leaf[63:58]. `rsp_level` is 0.
- R6: An entry with bit 0 clear gives status 1 (miss), with `rsp_level` 3, 2 or 1 for the root, intermediate or leaf table. No further read is issued and the decoded fields are 0.
- R7: A read answered with `mem_rsp_err` high gives status 2 (error). All other response fields are 0 and no further read is issued.
- R8: Only one lookup is in flight at a time. `req_ready` stays low from acceptance until the response handshake, and no new read is issued while one is outstanding.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response fields do not change.
- R10: Virtual address bits 15:0 have no effect on the reads issued or on the response.
- R11: Once `mem_req_valid` is raised, it and `mem_req_addr` stay stable until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | 64 | Byte address of the root table, sampled at request acceptance |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Walker idle and able to accept a lookup |
| req_vaddr | input | 48 | Virtual address to translate |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 64 | Byte address of the 64-bit entry to read |
| mem_rsp_valid | input | 1 | Read data returned (one cycle pulse) |
| mem_rsp_data | input | 64 | Entry read from memory |
| mem_rsp_err | input | 1 | Read failed, qualifies mem_rsp_valid |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Client accepts the response |
| rsp_status | output | 2 | 0 hit, 1 miss, 2 error |
| rsp_level | output | 2 | On miss, the table level (3, 2, 1) with the invalid entry |
| rsp_aux_addr | output | 48 | Auxiliary data address (256-byte aligned) |
| rsp_format | output | 6 | Surface format code from the leaf |
| rsp_chroma | output | 1 | 0 luma plane, 1 chroma plane |
| rsp_depth | output | 3 | Bit-depth code from the leaf |
| rsp_tile | output | 2 | Tile mode: 0 Ys, 1 Y, 2 and 3 reserved |

## Verification
Random walks use fresh tables every time. The pointer fields have random bit-47 values, and the bits outside each pointer field are filled with random junk. This separates correct field masking and canonical sign extension from a design that passes raw entry bits through. Directed walks with a cleared valid flag at each of the three levels, and with a read error injected on each of the three reads, show whether the walk stops at the right place with the right code and issues no extra reads. Repeating a lookup with only the low 16 address bits changed, and holding off response acceptance for several cycles, covers the ignored-bit and hold-stable rules. Random stalls on the read-request channel cover the hold rule on that side.

// File: rtl/aux_walk_pkg.sv
package aux_walk_pkg;

  localparam int ENT_W     = 64;
  localparam int VALID_BIT = 0;

  localparam int TILE_LSB  = 52;
  localparam int TILE_W    = 2;
  localparam int DEPTH_LSB = 54;
  localparam int DEPTH_W   = 3;
  localparam int PLANE_BIT = 57;
  localparam int FMT_LSB   = 58;
  localparam int FMT_W     = 6;

  typedef enum logic [1:0] {
    RS_HIT  = 2'd0,
    RS_MISS = 2'd1,
    RS_ERR  = 2'd2
  } rsp_code_e;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_REQ  = 2'd1,
    WS_WAIT = 2'd2,
    WS_RESP = 2'd3
  } walk_state_e;

  typedef struct packed {
    logic [FMT_W-1:0]   fmt;
    logic               chroma;
    logic [DEPTH_W-1:0] depth;
    logic [TILE_W-1:0]  tile;
  } leaf_attr_t;

endpackage

// File: rtl/aux_walk_index.sv
module aux_walk_index #(
  parameter int VA_W     = 48,
  parameter int PAGE_LSB = 16,
  parameter int L1_W     = 8,
  parameter int L2_W     = 12,
  parameter int L3_W     = 12
) (
  input  logic [VA_W-1:0] vaddr,
  output logic [L3_W-1:0] idx3,
  output logic [L2_W-1:0] idx2,
  output logic [L1_W-1:0] idx1
);
  localparam int L1_LSB = PAGE_LSB;
  localparam int L2_LSB = L1_LSB + L1_W;
  localparam int L3_LSB = L2_LSB + L2_W;

  logic unused_page_bits;

  assign idx1 = vaddr[L1_LSB +: L1_W];
  assign idx2 = vaddr[L2_LSB +: L2_W];
  assign idx3 = vaddr[L3_LSB +: L3_W];
  assign unused_page_bits = ^vaddr[PAGE_LSB-1:0];
endmodule

// File: rtl/aux_walk_ptr.sv
module aux_walk_ptr #(
  parameter int VA_W      = 48,
  parameter int FIELD_LSB = 15,
  parameter int IDX_W     = 12
) (
  input  logic [63:0]      entry,
  input  logic [IDX_W-1:0] idx,
  output logic [63:0]      entry_addr
);
  localparam logic [63:0] FIELD_MASK =
    ((64'd1 << VA_W) - 64'd1) & ~((64'd1 << FIELD_LSB) - 64'd1);

  logic [63:0] field;
  logic [63:0] canon;
  logic [63:0] offset;

  assign field  = entry & FIELD_MASK;
  assign canon  = {{(64-VA_W){field[VA_W-1]}}, field[VA_W-1:0]};
  assign offset = {{(64-IDX_W){1'b0}}, idx} << 3;
  assign entry_addr = canon + offset;
endmodule

// File: rtl/aux_walk_leaf.sv
module aux_walk_leaf
  import aux_walk_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int AUX_LSB = 8
) (
  input  logic [63:0]     entry,
  output logic [VA_W-1:0] aux_addr,
  output leaf_attr_t      attr
);
  logic unused_leaf_bits;

  assign aux_addr    = {entry[VA_W-1:AUX_LSB], {AUX_LSB{1'b0}}};
  assign attr.fmt    = entry[FMT_LSB +: FMT_W];
  assign attr.chroma = entry[PLANE_BIT];
  assign attr.depth  = entry[DEPTH_LSB +: DEPTH_W];
  assign attr.tile   = entry[TILE_LSB +: TILE_W];
  assign unused_leaf_bits = ^{entry[TILE_LSB-1:VA_W], entry[AUX_LSB-1:0]};
endmodule

// File: rtl/aux_walk_top.sv
module aux_walk_top
  import aux_walk_pkg::*;
#(
  parameter int VA_W     = 48,
  parameter int PAGE_LSB = 16,
  parameter int L1_W     = 8,
  parameter int L2_W     = 12,
  parameter int L3_W     = 12,
  parameter int L2_PTR_LSB = 15,
  parameter int L1_PTR_LSB = 13,
  parameter int AUX_LSB  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [63:0]       base_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [63:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_status,
  output logic [1:0]        rsp_level,
  output logic [VA_W-1:0]   rsp_aux_addr,
  output logic [FMT_W-1:0]  rsp_format,
  output logic              rsp_chroma,
  output logic [DEPTH_W-1:0] rsp_depth,
  output logic [TILE_W-1:0] rsp_tile
);
  localparam logic [1:0] LVL_ROOT = 2'd3;
  localparam logic [1:0] LVL_MID  = 2'd2;
  localparam logic [1:0] LVL_LEAF = 2'd1;

  walk_state_e      state;
  logic [1:0]       lvl;
  logic [VA_W-1:0]  va_q;
  logic [VA_W-1:0]  va_src;
  logic [L3_W-1:0]  idx3;
  logic [L2_W-1:0]  idx2;
  logic [L1_W-1:0]  idx1;
  logic [63:0]      root_off;
  logic [63:0]      mid_addr;
  logic [63:0]      leaf_addr;
  logic [VA_W-1:0]  leaf_aux;
  leaf_attr_t       leaf_attr;

  // Index source: live request while idle (root read), captured address afterwards.
  assign va_src = (state == WS_IDLE) ? req_vaddr : va_q;

  aux_walk_index #(
    .VA_W(VA_W), .PAGE_LSB(PAGE_LSB), .L1_W(L1_W), .L2_W(L2_W), .L3_W(L3_W)
  ) u_index (
    .vaddr(va_src), .idx3(idx3), .idx2(idx2), .idx1(idx1)
  );

  assign root_off = {{(64-L3_W){1'b0}}, idx3} << 3;

  aux_walk_ptr #(.VA_W(VA_W), .FIELD_LSB(L2_PTR_LSB), .IDX_W(L2_W)) u_ptr_mid (
    .entry(mem_rsp_data), .idx(idx2), .entry_addr(mid_addr)
  );

  aux_walk_ptr #(.VA_W(VA_W), .FIELD_LSB(L1_PTR_LSB), .IDX_W(L1_W)) u_ptr_leaf (
    .entry(mem_rsp_data), .idx(idx1), .entry_addr(leaf_addr)
  );

  aux_walk_leaf #(.VA_W(VA_W), .AUX_LSB(AUX_LSB)) u_leaf (
    .entry(mem_rsp_data), .aux_addr(leaf_aux), .attr(leaf_attr)
  );

  assign req_ready = (state == WS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= WS_IDLE;
      lvl           <= 2'd0;
      va_q          <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      rsp_valid     <= 1'b0;
      rsp_status    <= RS_HIT;
      rsp_level     <= 2'd0;
      rsp_aux_addr  <= '0;
      rsp_format    <= '0;
      rsp_chroma    <= 1'b0;
      rsp_depth     <= '0;
      rsp_tile      <= '0;
    end else begin
      unique case (state)
        WS_IDLE: begin
          if (req_valid) begin
            va_q          <= req_vaddr;
            lvl           <= LVL_ROOT;
            mem_req_addr  <= base_addr + root_off;
            mem_req_valid <= 1'b1;
            state         <= WS_REQ;
          end
        end
        WS_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state         <= WS_WAIT;
          end
        end
        WS_WAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              rsp_valid    <= 1'b1;
              rsp_status   <= RS_ERR;
              rsp_level    <= 2'd0;
              rsp_aux_addr <= '0;
              rsp_format   <= '0;
              rsp_chroma   <= 1'b0;
              rsp_depth    <= '0;
              rsp_tile     <= '0;
              state        <= WS_RESP;
            end else if (!mem_rsp_data[VALID_BIT]) begin
              rsp_valid    <= 1'b1;
              rsp_status   <= RS_MISS;
              rsp_level    <= lvl;
              rsp_aux_addr <= '0;
              rsp_format   <= '0;
              rsp_chroma   <= 1'b0;
              rsp_depth    <= '0;
              rsp_tile     <= '0;
              state        <= WS_RESP;
            end else if (lvl == LVL_LEAF) begin
              rsp_valid    <= 1'b1;
              rsp_status   <= RS_HIT;
              rsp_level    <= 2'd0;
              rsp_aux_addr <= leaf_aux;
              rsp_format   <= leaf_attr.fmt;
              rsp_chroma   <= leaf_attr.chroma;
              rsp_depth    <= leaf_attr.depth;
              rsp_tile     <= leaf_attr.tile;
              state        <= WS_RESP;
            end else begin
              mem_req_addr  <= (lvl == LVL_ROOT) ? mid_addr : leaf_addr;
              lvl           <= (lvl == LVL_ROOT) ? LVL_MID : LVL_LEAF;
              mem_req_valid <= 1'b1;
              state         <= WS_REQ;
            end
          end
        end
        WS_RESP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state     <= WS_IDLE;
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_walk_chk.sv
module aux_walk_chk
  import aux_walk_pkg::*;
#(
  parameter int VA_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [63:0]       mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_status,
  input logic [1:0]        rsp_level,
  input logic [VA_W-1:0]   rsp_aux_addr,
  input logic [FMT_W-1:0]  rsp_format,
  input logic              rsp_chroma,
  input logic [DEPTH_W-1:0] rsp_depth,
  input logic [TILE_W-1:0] rsp_tile
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (rst) outstanding <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
    else if (mem_rsp_valid) outstanding <= 1'b0;
  end

  // R8: not ready while a walk or response is pending
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid || rsp_valid || outstanding) |-> !req_ready);

  // R8: a single read in flight
  a_r8_single_read: assert property (@(posedge clk) disable iff (rst)
    outstanding |-> !mem_req_valid);

  // R2: an accepted lookup starts with a read request
  a_r2_first_read: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_req_valid && !req_ready));

  // R11: read request held until taken
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R9: response held until taken
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable({rsp_status, rsp_level,
      rsp_aux_addr, rsp_format, rsp_chroma, rsp_depth, rsp_tile})));

  // R6: a miss names a level
  a_r6_miss_level: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == RS_MISS) |-> (rsp_level != 2'd0));

  // R7: an error carries no translated fields
  a_r7_err_clean: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == RS_ERR) |-> (rsp_level == 2'd0 && rsp_aux_addr == '0
      && rsp_format == '0 && !rsp_chroma && rsp_depth == '0 && rsp_tile == '0));
endmodule

bind aux_walk_top aux_walk_chk #(.VA_W(VA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
  .rsp_level(rsp_level), .rsp_aux_addr(rsp_aux_addr), .rsp_format(rsp_format),
  .rsp_chroma(rsp_chroma), .rsp_depth(rsp_depth), .rsp_tile(rsp_tile)
);

// File: tb/sim_aux_walk_top.sv
`timescale 1ns/1ps
module sim_aux_walk_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] base_addr = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_vaddr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        mem_rsp_err;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [1:0]  rsp_status;
  logic [1:0]  rsp_level;
  logic [47:0] rsp_aux_addr;
  logic [5:0]  rsp_format;
  logic        rsp_chroma;
  logic [2:0]  rsp_depth;
  logic [1:0]  rsp_tile;

  aux_walk_top u0 (.*);

  always #2 clk = ~clk;

  logic [63:0] mem [logic [63:0]];
  int n_chk = 0;
  int n_fail = 0;
  int rd_n = 0;
  int err_step = 0;
  logic [63:0] rd_addr [0:3];

  int          e_n;
  logic [63:0] e_addr [0:3];
  logic [1:0]  e_status, e_level;
  logic [47:0] e_aux;
  logic [5:0]  e_fmt;
  logic        e_chroma;
  logic [2:0]  e_depth;
  logic [1:0]  e_tile;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] rdmem(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [63:0] fmask(input int lsb);
    return ((64'd1 << 48) - 64'd1) & ~((64'd1 << lsb) - 64'd1);
  endfunction

  function automatic logic [63:0] canon(input logic [63:0] e, input int lsb);
    logic [63:0] f;
    f = e & fmask(lsb);
    return {{16{f[47]}}, f[47:0]};
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [63:0] mk_ptr_entry(input logic [63:0] tbl, input int lsb, input bit v);
    return (rnd64() & ~fmask(lsb) & ~64'h1) | (tbl & fmask(lsb)) | {63'd0, v};
  endfunction

  function automatic logic [63:0] rnd_tbl(input int lsb, input bit hi);
    logic [63:0] t;
    t = rnd64() & fmask(lsb);
    t[47] = hi;
    return {{16{t[47]}}, t[47:0]};
  endfunction

  // Independent reference walk over the bench memory
  task automatic ref_walk(input logic [63:0] base, input logic [47:0] va, input int estep);
    logic [63:0] a, d;
    e_n = 0; e_status = 2'd0; e_level = 2'd0; e_aux = '0;
    e_fmt = '0; e_chroma = 1'b0; e_depth = '0; e_tile = '0;
    a = base + ({52'd0, va[47:36]} << 3);
    for (int l = 3; l >= 1; l--) begin
      e_addr[e_n] = a;
      e_n++;
      if (e_n == estep) begin e_status = 2'd2; return; end
      d = rdmem(a);
      if (!d[0]) begin e_status = 2'd1; e_level = 2'(l); return; end
      if (l == 1) begin
        e_aux = {d[47:8], 8'h00};
        e_tile = d[53:52]; e_depth = d[56:54]; e_chroma = d[57]; e_fmt = d[63:58];
        return;
      end
      if (l == 3) a = canon(d, 15) + ({52'd0, va[35:24]} << 3);
      else        a = canon(d, 13) + ({56'd0, va[23:16]} << 3);
    end
  endtask

  // Fresh tables; miss_lvl selects which level's entry is invalid (0 none)
  task automatic build(input logic [63:0] base, input logic [47:0] va, input int miss_lvl,
                       input bit hi2, input bit hi1);
    logic [63:0] t2, t1, a3, a2, a1;
    mem.delete();
    t2 = rnd_tbl(15, hi2);
    t1 = rnd_tbl(13, hi1);
    a3 = base + ({52'd0, va[47:36]} << 3);
    mem[a3] = mk_ptr_entry(t2, 15, miss_lvl != 3);
    if (miss_lvl == 3) return;
    a2 = t2 + ({52'd0, va[35:24]} << 3);
    mem[a2] = mk_ptr_entry(t1, 13, miss_lvl != 2);
    if (miss_lvl == 2) return;
    a1 = t1 + ({56'd0, va[23:16]} << 3);
    mem[a1] = (rnd64() & ~64'h1) | {63'd0, miss_lvl != 1};
  endtask

  // Memory responder
  initial begin
    logic [63:0] a;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_err = 1'b0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = '0;
      mem_req_ready = ($urandom % 4) != 0;
      if (!rst && mem_req_valid && mem_req_ready) begin
        a = mem_req_addr;
        if (rd_n < 4) rd_addr[rd_n] = a;
        rd_n++;
        repeat (1 + $urandom % 3) begin
          @(negedge clk);
          mem_req_ready = 1'b0;
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rdmem(a);
        mem_rsp_err   = (rd_n == err_step);
      end
    end
  end

  task automatic lookup(input logic [63:0] base, input logic [47:0] va, input int estep,
                        input int hold, input string tag);
    logic [63:0] snap;
    rd_n = 0;
    err_step = estep;
    ref_walk(base, va, estep);
    @(negedge clk);
    base_addr = base; req_vaddr = va; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, {"R8 ready low after accept ", tag}, {63'd0, req_ready}, 64'd0);
    while (!rsp_valid) @(negedge clk);
    chk(req_ready == 1'b0, {"R8 ready low with response ", tag}, {63'd0, req_ready}, 64'd0);
    chk(rsp_status == e_status, {"R5/R6/R7 status ", tag}, {62'd0, rsp_status}, {62'd0, e_status});
    chk(rsp_level == e_level, {"R6 level ", tag}, {62'd0, rsp_level}, {62'd0, e_level});
    chk(rsp_aux_addr == e_aux, {"R5 aux addr ", tag}, {16'd0, rsp_aux_addr}, {16'd0, e_aux});
    chk({rsp_format, rsp_chroma, rsp_depth, rsp_tile} == {e_fmt, e_chroma, e_depth, e_tile},
        {"R5 attr ", tag}, {52'd0, rsp_format, rsp_chroma, rsp_depth, rsp_tile},
        {52'd0, e_fmt, e_chroma, e_depth, e_tile});
    chk(rd_n == e_n, {"R6/R7 read count ", tag}, 64'(rd_n), 64'(e_n));
    for (int i = 0; i < 3; i++)
      if (i < e_n && i < rd_n)
        chk(rd_addr[i] == e_addr[i], {"R2/R3/R4 read addr ", tag}, rd_addr[i], e_addr[i]);
    snap = {rsp_aux_addr, rsp_format, rsp_chroma, rsp_depth, rsp_tile, rsp_status};
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && snap == {rsp_aux_addr, rsp_format, rsp_chroma, rsp_depth, rsp_tile, rsp_status},
          {"R9 hold ", tag}, {16'd0, rsp_aux_addr}, snap);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, {"R8 idle after handshake ", tag},
        {62'd0, req_ready, rsp_valid}, 64'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] base;
    logic [47:0] va;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", {63'd0, req_ready}, 64'd1);
    chk(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1 idle outputs after reset",
        {62'd0, rsp_valid, mem_req_valid}, 64'd0);

    // Directed: hits with both sign choices on the pointers (R2 R3 R4 R5)
    base = 64'h0000_1234_5678_0000 & ~64'h7fff;
    va = 48'hABC_DEF_12_3456;
    build(base, va, 0, 1'b1, 1'b0); lookup(base, va, 0, 2, "hit hi2");
    build(base, va, 0, 1'b0, 1'b1); lookup(base, va, 0, 0, "hit hi1");
    // R10: only low bits differ, same tables
    lookup(base, {va[47:16], 16'hFFFF}, 0, 1, "R10 low bits ones");
    lookup(base, {va[47:16], 16'h0000}, 0, 0, "R10 low bits zero");
    // R6 miss at each level
    build(base, va, 3, 1'b0, 1'b0); lookup(base, va, 0, 0, "R6 miss root");
    build(base, va, 2, 1'b1, 1'b0); lookup(base, va, 0, 0, "R6 miss mid");
    build(base, va, 1, 1'b1, 1'b1); lookup(base, va, 0, 3, "R6 miss leaf");
    // R7 error on each read
    build(base, va, 0, 1'b1, 1'b1); lookup(base, va, 1, 0, "R7 err first");
    lookup(base, va, 2, 1, "R7 err second");
    lookup(base, va, 3, 0, "R7 err third");
    // Extreme indices
    va = 48'hFFF_FFF_FF_0000;
    build(64'hFFFF_8000_0000_0000, va, 0, 1'b1, 1'b1);
    lookup(64'hFFFF_8000_0000_0000, va, 0, 0, "R2 max index");

    // Random
    for (int k = 0; k < 150; k++) begin
      int ml, es;
      base = rnd64() & ~64'h7fff;
      va = rnd64()[47:0];
      ml = ($urandom % 4 == 0) ? int'($urandom % 4) : 0;
      es = ($urandom % 6 == 0) ? int'(1 + $urandom % 3) : 0;
      build(base, va, ml, 1'($urandom), 1'($urandom));
      lookup(base, va, es, int'($urandom % 3), "random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule